// File: doc/BRIEF.md
# SPI Receive Queue with Watermark and Frame Match

This block is the receive half of a serial peripheral interface port. Bits arrive on a serial data line. Each one is taken on a one-cycle capture strobe, which the clocking logic upstream derives from the shift clock. The bits are assembled most significant first into frames of 8 or 16 bits. Each complete frame goes into a small receive queue, and software empties the queue through a register-style read port.

Two events can raise the single interrupt line. The first is a near-full flag. It rises when the queue holds more entries than a software-selected watermark, counted in words for 16-bit frames and in bytes for 8-bit frames. The second is a match flag. It rises when an arriving frame equals a programmed compare value. The near-full flag either follows the occupancy or stays set until software clears it, under the control of a mode bit. A frame that arrives while the queue is full is discarded and sets a sticky overrun flag.

Top module: `spi_rx_match_fifo`

## Requirements
- R1: Bits are taken on `sdi` in each cycle where `sck_cap` and `frame_act` are both 1, most significant bit first. When `frame_16`=1 a frame is 16 bits; when `frame_16`=0 it is 8 bits, and the entry is zero-extended to 16 bits. A frame enters the queue once its last bit is taken.
- R2: `fifo_count` gives the occupancy in frames. It is 0 after reset. It can reach 4 entries with `frame_16`=1 and 8 entries with `frame_16`=0.
- R3: A frame that completes while the queue is at capacity is dropped, and `fifo_count` keeps its value. The frame also sets `overrun`, which stays 1 until reset.
- R4: A one-cycle `rd_en` pulse removes the oldest entry and presents it on `rd_data` in the following cycle, so entries come out in arrival order. A read while the queue is empty gives 0 and leaves `fifo_count` unchanged.
- R5: With `wm_sel`=0, `near_full` goes to 1 when more than 3 words (16-bit frames) or more than 6 bytes (8-bit frames) are held.
- R6: With `wm_sel`=1, `near_full` goes to 1 when more than 2 words or more than 4 bytes are held.
- R7: With `clr_mode`=0, `near_full` returns to 0 as soon as occupancy is at or below the watermark.
- R8: With `clr_mode`=1, `near_full` stays 1 after occupancy falls until a 1 is pulsed on `nf_clr`. A pulse that arrives while occupancy is still above the watermark leaves it at 1.
- R9: With `match_ie`=1, a completed frame equal to `match_val` sets `match_flag`. In 8-bit mode only the low byte of `match_val` is compared. With `match_ie`=0 a frame never sets `match_flag`.
- R10: A 1 on `match_clr` clears `match_flag`.
- R11: `irq` is 1 exactly when `near_full` and `nf_ie` are both 1, or when `match_flag` and `match_ie` are both 1.
- R12: With `frame_act`=0 the bit position returns to the start of a frame, so a partly received frame is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_act | input | 1 | Frame window; 0 resets bit position |
| sck_cap | input | 1 | One-cycle capture strobe per bit |
| sdi | input | 1 | Serial data in |
| frame_16 | input | 1 | 1 = 16-bit frames, 0 = 8-bit frames |
| wm_sel | input | 1 | Watermark select |
| clr_mode | input | 1 | 0 = near-full follows level, 1 = clear by write |
| nf_ie | input | 1 | Near-full interrupt enable |
| match_ie | input | 1 | Match compare and interrupt enable |
| match_val | input | 16 | Compare value |
| nf_clr | input | 1 | Write-one clear of near-full |
| match_clr | input | 1 | Write-one clear of match flag |
| rd_en | input | 1 | Pop request |
| rd_data | output | 16 | Popped entry, valid the cycle after `rd_en` |
| fifo_count | output | 4 | Entries held |
| near_full | output | 1 | Watermark flag |
| match_flag | output | 1 | Frame-equal flag |
| overrun | output | 1 | Sticky drop flag |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the block with the default queue depth of 8 bytes. This depth gives watermarks of 3 and 2 words, or 6 and 4 bytes. At that depth a handful of frames is enough to cross every watermark in both frame sizes, to fill the queue and to overrun it. Short back-to-back bursts therefore reach the corners where occupancy equals the watermark, equals capacity, or falls from above the watermark back to it.

// File: rtl/spirx_pkg.sv
package spirx_pkg;
  localparam int FRAME_W = 16;

  // Watermark in stored entries: byte figure first, halved for word frames.
  function automatic int nf_limit(input logic wide, input logic wm, input int depth);
    int byte_lim;
    byte_lim = wm ? depth / 2 : depth - 2;
    return wide ? byte_lim / 2 : byte_lim;
  endfunction

  function automatic logic frame_hit(input logic [FRAME_W-1:0] d,
                                     input logic [FRAME_W-1:0] v,
                                     input logic wide);
    return wide ? (d == v) : (d[7:0] == v[7:0]);
  endfunction
endpackage

// File: rtl/spirx_shifter.sv
module spirx_shifter
  import spirx_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               frame_act,
  input  logic               sck_cap,
  input  logic               sdi,
  input  logic               frame_16,
  output logic               done,
  output logic [FRAME_W-1:0] data
);
  localparam int BCW = $clog2(FRAME_W);

  logic [FRAME_W-2:0] sh;
  logic [BCW-1:0]     bitcnt;
  logic [BCW-1:0]     last_bit;

  assign last_bit = frame_16 ? BCW'(FRAME_W - 1) : BCW'(7);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sh     <= '0;
      bitcnt <= '0;
      done   <= 1'b0;
      data   <= '0;
    end else begin
      done <= 1'b0;
      if (!frame_act) begin
        bitcnt <= '0;
      end else if (sck_cap) begin
        sh <= {sh[FRAME_W-3:0], sdi};
        if (bitcnt == last_bit) begin
          bitcnt <= '0;
          done   <= 1'b1;
          data   <= frame_16 ? {sh, sdi} : {8'h00, sh[6:0], sdi};
        end else begin
          bitcnt <= bitcnt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/spirx_queue.sv
module spirx_queue
  import spirx_pkg::*;
#(
  parameter int DEPTH = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       frame_16,
  input  logic                       push,
  input  logic [FRAME_W-1:0]         push_data,
  input  logic                       pop,
  output logic [FRAME_W-1:0]         rd_data,
  output logic [$clog2(DEPTH+1)-1:0] count,
  output logic [$clog2(DEPTH+1)-1:0] count_nxt,
  output logic                       push_drop
);
  localparam int CW = $clog2(DEPTH + 1);
  localparam int PW = $clog2(DEPTH);

  logic [FRAME_W-1:0] mem [DEPTH];
  logic [PW-1:0]      wp, rp;
  logic [CW-1:0]      cap;
  logic               push_ok, pop_ok;

  assign cap       = frame_16 ? CW'(DEPTH / 2) : CW'(DEPTH);
  assign push_ok   = push && (count < cap);
  assign push_drop = push && (count >= cap);
  assign pop_ok    = pop && (count != '0);
  assign count_nxt = count + CW'(push_ok) - CW'(pop_ok);

  always_ff @(posedge clk) begin
    if (push_ok) mem[wp] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp      <= '0;
      rp      <= '0;
      count   <= '0;
      rd_data <= '0;
    end else begin
      count <= count_nxt;
      if (push_ok) wp <= wp + 1'b1;
      if (pop) begin
        if (pop_ok) begin
          rd_data <= mem[rp];
          rp      <= rp + 1'b1;
        end else begin
          rd_data <= '0;
        end
      end
    end
  end
endmodule

// File: rtl/spirx_flags.sv
module spirx_flags
  import spirx_pkg::*;
#(
  parameter int DEPTH = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       frame_16,
  input  logic                       wm_sel,
  input  logic                       clr_mode,
  input  logic                       nf_ie,
  input  logic                       match_ie,
  input  logic [FRAME_W-1:0]         match_val,
  input  logic                       nf_clr,
  input  logic                       match_clr,
  input  logic                       frame_done,
  input  logic [FRAME_W-1:0]         frame_data,
  input  logic                       push_drop,
  input  logic [$clog2(DEPTH+1)-1:0] count_nxt,
  output logic                       near_full,
  output logic                       match_flag,
  output logic                       overrun,
  output logic                       irq
);
  logic above_nxt;
  logic hit_evt;

  assign above_nxt = int'(count_nxt) > nf_limit(frame_16, wm_sel, DEPTH);
  assign hit_evt   = frame_done && match_ie && frame_hit(frame_data, match_val, frame_16);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      near_full  <= 1'b0;
      match_flag <= 1'b0;
      overrun    <= 1'b0;
    end else begin
      near_full <= above_nxt || (clr_mode && near_full && !nf_clr);
      if (hit_evt)        match_flag <= 1'b1;
      else if (match_clr) match_flag <= 1'b0;
      if (push_drop)      overrun    <= 1'b1;
    end
  end

  assign irq = (near_full && nf_ie) || (match_flag && match_ie);
endmodule

// File: rtl/spi_rx_match_fifo.sv
module spi_rx_match_fifo
  import spirx_pkg::*;
#(
  parameter int DEPTH = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       frame_act,
  input  logic                       sck_cap,
  input  logic                       sdi,
  input  logic                       frame_16,
  input  logic                       wm_sel,
  input  logic                       clr_mode,
  input  logic                       nf_ie,
  input  logic                       match_ie,
  input  logic [15:0]                match_val,
  input  logic                       nf_clr,
  input  logic                       match_clr,
  input  logic                       rd_en,
  output logic [15:0]                rd_data,
  output logic [$clog2(DEPTH+1)-1:0] fifo_count,
  output logic                       near_full,
  output logic                       match_flag,
  output logic                       overrun,
  output logic                       irq
);
  localparam int CW = $clog2(DEPTH + 1);

  logic               frame_done;
  logic [FRAME_W-1:0] frame_data;
  logic [CW-1:0]      count_nxt;
  logic               push_drop;

  spirx_shifter u_shift (
    .clk, .rst_n, .frame_act, .sck_cap, .sdi, .frame_16,
    .done(frame_done), .data(frame_data)
  );

  spirx_queue #(.DEPTH(DEPTH)) u_queue (
    .clk, .rst_n, .frame_16,
    .push(frame_done), .push_data(frame_data), .pop(rd_en),
    .rd_data, .count(fifo_count), .count_nxt, .push_drop
  );

  spirx_flags #(.DEPTH(DEPTH)) u_flags (
    .clk, .rst_n, .frame_16, .wm_sel, .clr_mode, .nf_ie, .match_ie,
    .match_val, .nf_clr, .match_clr, .frame_done, .frame_data,
    .push_drop, .count_nxt, .near_full, .match_flag, .overrun, .irq
  );
endmodule

// File: rtl/spi_rx_match_fifo_chk.sv
module spi_rx_match_fifo_chk #(
  parameter int DEPTH = 8
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       frame_16,
  input logic                       wm_sel,
  input logic                       clr_mode,
  input logic                       nf_clr,
  input logic                       nf_ie,
  input logic                       match_ie,
  input logic                       rd_en,
  input logic [15:0]                rd_data,
  input logic [$clog2(DEPTH+1)-1:0] fifo_count,
  input logic                       near_full,
  input logic                       match_flag,
  input logic                       overrun,
  input logic                       irq,
  input logic                       frame_done
);
  int thr;
  int cap;
  always_comb begin
    thr = frame_16 ? (wm_sel ? DEPTH / 4 : (DEPTH - 2) / 2)
                   : (wm_sel ? DEPTH / 2 : DEPTH - 2);
    cap = frame_16 ? DEPTH / 2 : DEPTH;
  end

  p_cap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    int'(fifo_count) <= DEPTH);

  p_ovr_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done && int'(fifo_count) == cap |=> overrun);

  p_ovr_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
    overrun |=> overrun);

  p_empty_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en && fifo_count == '0 && !frame_done |=> rd_data == 16'h0000 && fifo_count == '0);

  p_nf_level_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_mode && $stable(clr_mode) && $stable(wm_sel) && $stable(frame_16)
      |-> near_full == (int'(fifo_count) > thr));

  p_nf_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    clr_mode && near_full && !nf_clr |=> near_full);

  p_match_en_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(match_flag) |-> $past(match_ie));

  p_irq_src_r11: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (near_full && nf_ie) || (match_flag && match_ie));
endmodule

bind spi_rx_match_fifo spi_rx_match_fifo_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .frame_16(frame_16), .wm_sel(wm_sel),
  .clr_mode(clr_mode), .nf_clr(nf_clr), .nf_ie(nf_ie), .match_ie(match_ie),
  .rd_en(rd_en), .rd_data(rd_data), .fifo_count(fifo_count),
  .near_full(near_full), .match_flag(match_flag), .overrun(overrun),
  .irq(irq), .frame_done(frame_done)
);

// File: tb/test_spi_rx_match_fifo.sv
module test_spi_rx_match_fifo;
  localparam int DEPTH = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic frame_act = 1'b1, sck_cap = 1'b0, sdi = 1'b0;
  logic frame_16 = 1'b1, wm_sel = 1'b0, clr_mode = 1'b0;
  logic nf_ie = 1'b0, match_ie = 1'b0, nf_clr = 1'b0, match_clr = 1'b0, rd_en = 1'b0;
  logic [15:0] match_val = 16'h0000;
  logic [15:0] rd_data;
  logic [3:0]  fifo_count;
  logic near_full, match_flag, overrun, irq;

  int checks = 0;
  int fails  = 0;
  int model_cnt = 0;
  logic [15:0] sb_q[$];

  always #5 clk = ~clk;

  spi_rx_match_fifo #(.DEPTH(DEPTH)) i_spi_rx_match_fifo (
    .clk, .rst_n, .frame_act, .sck_cap, .sdi, .frame_16, .wm_sel, .clr_mode,
    .nf_ie, .match_ie, .match_val, .nf_clr, .match_clr, .rd_en,
    .rd_data, .fifo_count, .near_full, .match_flag, .overrun, .irq
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Driver: shifts one frame MSB first and records what the queue should hold.
  task automatic send(input logic [15:0] v);
    int nb;
    int capn;
    nb   = frame_16 ? 16 : 8;
    capn = frame_16 ? DEPTH / 2 : DEPTH;
    for (int i = nb - 1; i >= 0; i--) begin
      @(negedge clk); sdi = v[i]; sck_cap = 1'b1;
    end
    @(negedge clk); sck_cap = 1'b0;
    repeat (3) @(negedge clk);
    if (model_cnt < capn) begin
      sb_q.push_back(frame_16 ? v : {8'h00, v[7:0]});
      model_cnt++;
    end
  endtask

  // Monitor: pops one entry and compares it against the scoreboard head.
  task automatic pop_check(input string req);
    logic [15:0] exp;
    exp = (sb_q.size() == 0) ? 16'h0000 : sb_q.pop_front();
    if (model_cnt > 0) model_cnt--;
    @(negedge clk); rd_en = 1'b1;
    @(negedge clk); rd_en = 1'b0;
    check(req, rd_data, exp);
  endtask

  task automatic pulse_nf_clr();
    @(negedge clk); nf_clr = 1'b1;
    @(negedge clk); nf_clr = 1'b0;
    @(negedge clk);
  endtask

  task automatic pulse_match_clr();
    @(negedge clk); match_clr = 1'b1;
    @(negedge clk); match_clr = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual expired expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R2 reset count", fifo_count, 0);
    check("R7 reset near_full", near_full, 0);
    check("R9 reset match", match_flag, 0);
    check("R3 reset overrun", overrun, 0);
    check("R11 reset irq", irq, 0);

    // 16-bit frames, watermark 3 words
    nf_ie = 1'b1;
    send(16'h1111); send(16'h2222); send(16'h3333);
    check("R2 three words", fifo_count, 3);
    check("R5 at watermark", near_full, 0);
    send(16'h4444);
    check("R5 above watermark", near_full, 1);
    check("R11 nf irq", irq, 1);
    send(16'h5555);
    check("R3 drop keeps count", fifo_count, 4);
    check("R3 overrun set", overrun, 1);
    pop_check("R4 order 1");
    check("R4 count after pop", fifo_count, 3);
    check("R7 auto clear", near_full, 0);
    check("R11 irq drops", irq, 0);
    pop_check("R4 order 2"); pop_check("R4 order 3"); pop_check("R4 order 4");
    pop_check("R4 empty read zero");
    check("R4 empty count", fifo_count, 0);
    check("R3 overrun sticky", overrun, 1);

    // watermark 2 words
    wm_sel = 1'b1;
    send(16'hABCD); send(16'h0F0F);
    check("R6 two words", near_full, 0);
    send(16'h8001);
    check("R6 three words", near_full, 1);
    pop_check("R6 pop a");
    check("R6 back to two", near_full, 0);
    pop_check("R6 pop b"); pop_check("R6 pop c");

    // 8-bit frames, watermark 6 bytes
    frame_16 = 1'b0; wm_sel = 1'b0;
    for (int k = 0; k < 6; k++) send(16'h00A0 + 16'(k));
    check("R1 bytes count", fifo_count, 6);
    check("R5 six bytes", near_full, 0);
    send(16'hFF3C);
    check("R5 seven bytes", near_full, 1);
    pop_check("R1 byte data");
    check("R7 byte auto clear", near_full, 0);
    @(negedge clk); wm_sel = 1'b1; @(negedge clk);
    check("R6 six bytes wm1", near_full, 1);
    pop_check("R1 byte b"); pop_check("R1 byte c");
    check("R6 four bytes", near_full, 0);
    for (int k = 0; k < 4; k++) pop_check("R1 byte drain");
    check("R2 byte empty", fifo_count, 0);

    // write-to-clear mode
    clr_mode = 1'b1;
    for (int k = 0; k < 5; k++) send(16'h0040 + 16'(k));
    check("R8 set", near_full, 1);
    pop_check("R8 pop");
    check("R8 held", near_full, 1);
    pulse_nf_clr();
    check("R8 cleared", near_full, 0);
    send(16'h0077);
    check("R8 reset again", near_full, 1);
    pulse_nf_clr();
    check("R8 clear while above", near_full, 1);
    for (int k = 0; k < 5; k++) pop_check("R8 drain");
    pulse_nf_clr();
    check("R8 final clear", near_full, 0);

    // match
    clr_mode = 1'b0; nf_ie = 1'b0; wm_sel = 1'b0; frame_16 = 1'b1;
    match_val = 16'hA5C3; match_ie = 1'b0;
    send(16'hA5C3);
    check("R9 disabled", match_flag, 0);
    pop_check("R9 pop");
    match_ie = 1'b1;
    send(16'hA5C3);
    check("R9 word match", match_flag, 1);
    check("R11 match irq", irq, 1);
    pop_check("R9 pop");
    pulse_match_clr();
    check("R10 clear", match_flag, 0);
    send(16'hA5C4);
    check("R9 word miss", match_flag, 0);
    pop_check("R9 pop");
    frame_16 = 1'b0; match_val = 16'h12A5;
    send(16'h00A5);
    check("R9 low byte match", match_flag, 1);
    pop_check("R9 pop");
    pulse_match_clr();
    send(16'h0012);
    check("R9 high byte ignored", match_flag, 0);
    pop_check("R9 pop");

    // partial frame discarded
    match_ie = 1'b0;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk); sdi = 1'b1; sck_cap = 1'b1;
    end
    @(negedge clk); sck_cap = 1'b0; frame_act = 1'b0;
    @(negedge clk); frame_act = 1'b1;
    send(16'h003C);
    check("R12 one frame", fifo_count, 1);
    pop_check("R12 aligned data");

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule